// File: doc/BRIEF.md
# Nested-Loop DMA Address Sequencer

This block steps a single DMA channel's transfer descriptor through a two-level transfer. Each service request starts one inner loop. The inner loop moves a programmed number of bytes as a series of reads and writes on a simple memory port. The port carries an address, a size code and a one-cycle enable for each access, with no data path. The outer loop counts inner loops down from a starting iteration count. When it reaches its end, the block applies final address corrections and rewinds the count so that the channel is ready to run again.

Software loads the whole descriptor in one cycle through the configuration inputs. That descriptor holds the start addresses, the signed per-access offsets, the size codes, the byte-count word (which can also hold a signed offset for the end of each inner loop), the end-of-outer-loop adjustments, the iteration count, a stall count and an interrupt enable. A peripheral or trigger then raises the service request once per inner loop. The block reports the end of each inner and outer loop with one-cycle pulses, keeps a sticky done flag, and refuses to run a descriptor that cannot be executed.

Top module: `xfer_loop_seq`

## Requirements
- R1: The read address starts at the loaded source address, and after every read the sign-extended 16-bit source offset is added to it. The write address behaves the same way with the destination offset after every write.
- R2: Size codes 0, 1, 2, 4 and 5 mean 1, 2, 4, 16 and 32 bytes, and `rdSize`/`wrSize` show the loaded codes. An inner loop is cut into units of the larger width. Each unit is all of its reads at the source width followed by all of its writes at the destination width, so an inner loop of N bytes makes N/srcWidth reads and N/dstWidth writes.
- R3: When `cfgMapEn` is 0, the full 32-bit byte-count word is the inner-loop byte count.
- R4: When `cfgMapEn` is 1, bit 31 of the byte-count word enables the source inner-loop offset and bit 30 enables the destination one. If either bit is set, bits 9:0 are the byte count, and bits 29:10, sign-extended, are added to each enabled address when an inner loop ends. If neither bit is set, bits 29:0 are the byte count.
- R5: `minorDone` pulses for one cycle in the cycle after the last write of an inner loop, and `curIter` drops by one at the same time unless the outer loop ends.
- R6: When an inner loop ends with `curIter` equal to 1, `majorDone` pulses together with `minorDone`, `curIter` reloads the starting count, `doneFlag` sets, and the source and destination end adjustments are added to the addresses on top of any step and inner-loop offset. `doneFlag` clears when the next request is accepted or a descriptor is loaded.
- R7: `irq` pulses together with `majorDone` only when the loaded interrupt enable is 1.
- R8: `active` is high from the cycle after an accepted request until the last access of the inner loop and its stall cycles are over. No access is issued while it is low, and a request that arrives while it is high is ignored.
- R9: With a stall count S, each read and each write is followed by S cycles with no access.
- R10: `cfgErr` is high when a size code is not one of the five valid codes, the byte count is zero or not a multiple of the larger width, or the starting count is zero. While it is high, requests are ignored. After reset the descriptor is cleared, so `cfgErr` is high.
- R11: A read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgLoad | input | 1 | Loads the descriptor from the cfg inputs |
| cfgSrcAddr | input | ADDR_W | Source start address |
| cfgDstAddr | input | ADDR_W | Destination start address |
| cfgSrcOff | input | 16 | Signed source step per read |
| cfgDstOff | input | 16 | Signed destination step per write |
| cfgSrcSize | input | 3 | Source size code |
| cfgDstSize | input | 3 | Destination size code |
| cfgByteWord | input | 32 | Byte count, with optional inner-loop offset fields |
| cfgMapEn | input | 1 | Selects the split byte-count word layout |
| cfgSrcLast | input | ADDR_W | Source adjustment at end of outer loop |
| cfgDstLast | input | ADDR_W | Destination adjustment at end of outer loop |
| cfgIter | input | ITER_W | Starting iteration count |
| cfgStall | input | STALL_W | Idle cycles after each access |
| cfgIntEn | input | 1 | Enables the end-of-outer-loop interrupt |
| svcReq | input | 1 | Service request, starts one inner loop |
| rdEn | output | 1 | Read strobe |
| rdAddr | output | ADDR_W | Read address |
| rdSize | output | 3 | Read size code |
| wrEn | output | 1 | Write strobe |
| wrAddr | output | ADDR_W | Write address |
| wrSize | output | 3 | Write size code |
| active | output | 1 | Inner loop in progress |
| minorDone | output | 1 | Inner-loop completion pulse |
| majorDone | output | 1 | Outer-loop completion pulse |
| doneFlag | output | 1 | Sticky outer-loop completion flag |
| irq | output | 1 | Outer-loop interrupt pulse |
| cfgErr | output | 1 | Descriptor cannot be executed |
| curIter | output | ITER_W | Remaining iterations |

## Verification
Some properties are checked on every cycle: reads and writes never overlap, no access is issued while idle, a request is refused while the descriptor is in error, the iteration count drops by exactly one at each plain inner-loop end, and outer-loop completion always comes with the inner-loop pulse, the done flag and any interrupt. Other behaviour can only be shown by the bench's scenarios, because it depends on the whole sequence of accesses: the exact address order, how units are split when the source and destination widths differ, how the byte-count word is decoded, the inner-loop offset, the end adjustments, and the spacing that the stall count sets between accesses.

// File: rtl/xfer_loop_pkg.sv
package xfer_loop_pkg;

  localparam int BYTE_WORD_W = 32;
  localparam int OFF_W       = 16;
  localparam int MLOFF_LSB   = 10;
  localparam int MLOFF_MSB   = 29;
  localparam int MLOFF_W     = MLOFF_MSB - MLOFF_LSB + 1;
  localparam int PER_UNIT_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_STALL
  } seqState_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic start;
    logic stepSrc;
    logic stepDst;
    logic minorEnd;
  } seqStrobe_t;

  function automatic logic sizeCodeOk(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
           (code == 3'd4) || (code == 3'd5);
  endfunction

endpackage

// File: rtl/xfer_addr_unit.sv
module xfer_addr_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              step,
  input  logic [ADDR_W-1:0] stepOff,
  input  logic              minorEnd,
  input  logic              mlEn,
  input  logic [ADDR_W-1:0] mlOff,
  input  logic              majorEnd,
  input  logic [ADDR_W-1:0] lastAdj,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addStep, addMl, addLast;

  always_comb begin
    addStep = step ? stepOff : '0;
    addMl   = (minorEnd && mlEn) ? mlOff : '0;
    addLast = majorEnd ? lastAdj : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     addr <= '0;
    else if (load) addr <= loadAddr;
    else           addr <= addr + addStep + addMl + addLast;
  end

endmodule

// File: rtl/xfer_loop_dp.sv
module xfer_loop_dp
  import xfer_loop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ITER_W  = 15,
  parameter int STALL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgLoad,
  input  logic [ADDR_W-1:0]      cfgSrcAddr,
  input  logic [ADDR_W-1:0]      cfgDstAddr,
  input  logic [OFF_W-1:0]       cfgSrcOff,
  input  logic [OFF_W-1:0]       cfgDstOff,
  input  logic [2:0]             cfgSrcSize,
  input  logic [2:0]             cfgDstSize,
  input  logic [BYTE_WORD_W-1:0] cfgByteWord,
  input  logic                   cfgMapEn,
  input  logic [ADDR_W-1:0]      cfgSrcLast,
  input  logic [ADDR_W-1:0]      cfgDstLast,
  input  logic [ITER_W-1:0]      cfgIter,
  input  logic [STALL_W-1:0]     cfgStall,
  input  logic                   cfgIntEn,
  input  seqStrobe_t             strb,
  output logic [ADDR_W-1:0]      rdAddr,
  output logic [ADDR_W-1:0]      wrAddr,
  output logic [2:0]             rdSize,
  output logic [2:0]             wrSize,
  output logic [BYTE_WORD_W-1:0] unitsTotal,
  output logic [PER_UNIT_W-1:0]  rdPerUnit,
  output logic [PER_UNIT_W-1:0]  wrPerUnit,
  output logic [STALL_W-1:0]     stallCyc,
  output logic                   cfgErr,
  output logic                   minorDone,
  output logic                   majorDone,
  output logic                   doneFlag,
  output logic                   irq,
  output logic [ITER_W-1:0]      curIter
);

  logic [OFF_W-1:0]       srcOff, dstOff;
  logic [BYTE_WORD_W-1:0] byteWord;
  logic                   mapEn, intEn;
  logic [ADDR_W-1:0]      srcLast, dstLast;
  logic [ITER_W-1:0]      beginIter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcOff <= '0; dstOff <= '0; rdSize <= '0; wrSize <= '0;
      byteWord <= '0; mapEn <= 1'b0; intEn <= 1'b0;
      srcLast <= '0; dstLast <= '0; beginIter <= '0; stallCyc <= '0;
    end else if (cfgLoad) begin
      srcOff <= cfgSrcOff; dstOff <= cfgDstOff;
      rdSize <= cfgSrcSize; wrSize <= cfgDstSize;
      byteWord <= cfgByteWord; mapEn <= cfgMapEn; intEn <= cfgIntEn;
      srcLast <= cfgSrcLast; dstLast <= cfgDstLast;
      beginIter <= cfgIter; stallCyc <= cfgStall;
    end
  end

  // byte-count word decode
  logic                   srcMlEn, dstMlEn;
  logic [BYTE_WORD_W-1:0] nBytes;
  logic [ADDR_W-1:0]      mlOffExt, srcOffExt, dstOffExt;
  logic [2:0]             maxCode;
  logic [BYTE_WORD_W-1:0] unitMask;

  always_comb begin
    srcMlEn = mapEn && byteWord[31];
    dstMlEn = mapEn && byteWord[30];
    if (!mapEn)                         nBytes = byteWord;
    else if (byteWord[31] || byteWord[30]) nBytes = {{(BYTE_WORD_W-MLOFF_LSB){1'b0}}, byteWord[MLOFF_LSB-1:0]};
    else                                nBytes = {2'b00, byteWord[MLOFF_MSB:0]};
    mlOffExt  = {{(ADDR_W-MLOFF_W){byteWord[MLOFF_MSB]}}, byteWord[MLOFF_MSB:MLOFF_LSB]};
    srcOffExt = {{(ADDR_W-OFF_W){srcOff[OFF_W-1]}}, srcOff};
    dstOffExt = {{(ADDR_W-OFF_W){dstOff[OFF_W-1]}}, dstOff};
    maxCode   = (rdSize > wrSize) ? rdSize : wrSize;
    unitMask  = (BYTE_WORD_W'(1) << maxCode) - BYTE_WORD_W'(1);
    unitsTotal = nBytes >> maxCode;
    rdPerUnit  = PER_UNIT_W'(1) << (maxCode - rdSize);
    wrPerUnit  = PER_UNIT_W'(1) << (maxCode - wrSize);
    cfgErr = !sizeCodeOk(rdSize) || !sizeCodeOk(wrSize) || (nBytes == '0) ||
             ((nBytes & unitMask) != '0) || (beginIter == '0);
  end

  logic majorEnd;
  assign majorEnd = strb.minorEnd && (curIter == ITER_W'(1));

  xfer_addr_unit #(.ADDR_W(ADDR_W)) u_srcAddr (
    .clk(clk), .rstN(rstN), .load(cfgLoad), .loadAddr(cfgSrcAddr),
    .step(strb.stepSrc), .stepOff(srcOffExt), .minorEnd(strb.minorEnd),
    .mlEn(srcMlEn), .mlOff(mlOffExt), .majorEnd(majorEnd), .lastAdj(srcLast),
    .addr(rdAddr)
  );

  xfer_addr_unit #(.ADDR_W(ADDR_W)) u_dstAddr (
    .clk(clk), .rstN(rstN), .load(cfgLoad), .loadAddr(cfgDstAddr),
    .step(strb.stepDst), .stepOff(dstOffExt), .minorEnd(strb.minorEnd),
    .mlEn(dstMlEn), .mlOff(mlOffExt), .majorEnd(majorEnd), .lastAdj(dstLast),
    .addr(wrAddr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIter <= '0; doneFlag <= 1'b0;
      minorDone <= 1'b0; majorDone <= 1'b0; irq <= 1'b0;
    end else begin
      minorDone <= strb.minorEnd;
      majorDone <= majorEnd;
      irq       <= majorEnd && intEn;
      if (cfgLoad) begin
        curIter  <= cfgIter;
        doneFlag <= 1'b0;
      end else begin
        if (strb.start) doneFlag <= 1'b0;
        if (majorEnd) begin
          curIter  <= beginIter;
          doneFlag <= 1'b1;
        end else if (strb.minorEnd) begin
          curIter <= curIter - ITER_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/xfer_loop_ctrl.sv
module xfer_loop_ctrl
  import xfer_loop_pkg::*;
#(
  parameter int STALL_W = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   svcReq,
  input  logic                   cfgErr,
  input  logic [BYTE_WORD_W-1:0] unitsTotal,
  input  logic [PER_UNIT_W-1:0]  rdPerUnit,
  input  logic [PER_UNIT_W-1:0]  wrPerUnit,
  input  logic [STALL_W-1:0]     stallCyc,
  output seqStrobe_t             strb,
  output logic                   active,
  output logic                   rdEn,
  output logic                   wrEn
);

  seqState_e              state, stateN, resume, resumeN, after;
  logic [BYTE_WORD_W-1:0] unitsLeft, unitsN;
  logic [PER_UNIT_W-1:0]  rdLeft, rdN, wrLeft, wrN;
  logic [STALL_W-1:0]     stallCnt, stallN;

  always_comb begin
    strb    = '0;
    stateN  = state;
    resumeN = resume;
    after   = state;
    unitsN  = unitsLeft;
    rdN     = rdLeft;
    wrN     = wrLeft;
    stallN  = stallCnt;
    case (state)
      ST_IDLE: begin
        if (svcReq && !cfgErr) begin
          strb.start = 1'b1;
          unitsN = unitsTotal;
          rdN    = rdPerUnit;
          wrN    = wrPerUnit;
          stateN = ST_READ;
        end
      end
      ST_READ: begin
        strb.stepSrc = 1'b1;
        if (rdLeft == PER_UNIT_W'(1)) after = ST_WRITE;
        else begin
          after = ST_READ;
          rdN   = rdLeft - PER_UNIT_W'(1);
        end
      end
      ST_WRITE: begin
        strb.stepDst = 1'b1;
        if (wrLeft == PER_UNIT_W'(1)) begin
          wrN = wrPerUnit;
          if (unitsLeft == BYTE_WORD_W'(1)) begin
            strb.minorEnd = 1'b1;
            after = ST_IDLE;
          end else begin
            unitsN = unitsLeft - BYTE_WORD_W'(1);
            rdN    = rdPerUnit;
            after  = ST_READ;
          end
        end else begin
          wrN   = wrLeft - PER_UNIT_W'(1);
          after = ST_WRITE;
        end
      end
      default: begin
        if (stallCnt <= STALL_W'(1)) stateN = resume;
        else stallN = stallCnt - STALL_W'(1);
      end
    endcase
    if (state == ST_READ || state == ST_WRITE) begin
      if (stallCyc != '0) begin
        stateN  = ST_STALL;
        stallN  = stallCyc;
        resumeN = after;
      end else begin
        stateN = after;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; resume <= ST_IDLE;
      unitsLeft <= '0; rdLeft <= '0; wrLeft <= '0; stallCnt <= '0;
    end else begin
      state <= stateN; resume <= resumeN;
      unitsLeft <= unitsN; rdLeft <= rdN; wrLeft <= wrN; stallCnt <= stallN;
    end
  end

  assign active = (state != ST_IDLE);
  assign rdEn   = (state == ST_READ);
  assign wrEn   = (state == ST_WRITE);

endmodule

// File: rtl/xfer_loop_seq.sv
module xfer_loop_seq
  import xfer_loop_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ITER_W  = 15,
  parameter int STALL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [ADDR_W-1:0]  cfgSrcAddr,
  input  logic [ADDR_W-1:0]  cfgDstAddr,
  input  logic [15:0]        cfgSrcOff,
  input  logic [15:0]        cfgDstOff,
  input  logic [2:0]         cfgSrcSize,
  input  logic [2:0]         cfgDstSize,
  input  logic [31:0]        cfgByteWord,
  input  logic               cfgMapEn,
  input  logic [ADDR_W-1:0]  cfgSrcLast,
  input  logic [ADDR_W-1:0]  cfgDstLast,
  input  logic [ITER_W-1:0]  cfgIter,
  input  logic [STALL_W-1:0] cfgStall,
  input  logic               cfgIntEn,
  input  logic               svcReq,
  output logic               rdEn,
  output logic [ADDR_W-1:0]  rdAddr,
  output logic [2:0]         rdSize,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [2:0]         wrSize,
  output logic               active,
  output logic               minorDone,
  output logic               majorDone,
  output logic               doneFlag,
  output logic               irq,
  output logic               cfgErr,
  output logic [ITER_W-1:0]  curIter
);

  seqStrobe_t             strb;
  logic [BYTE_WORD_W-1:0] unitsTotal;
  logic [PER_UNIT_W-1:0]  rdPerUnit, wrPerUnit;
  logic [STALL_W-1:0]     stallCyc;

  xfer_loop_ctrl #(.STALL_W(STALL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .svcReq(svcReq), .cfgErr(cfgErr),
    .unitsTotal(unitsTotal), .rdPerUnit(rdPerUnit), .wrPerUnit(wrPerUnit),
    .stallCyc(stallCyc), .strb(strb), .active(active), .rdEn(rdEn), .wrEn(wrEn)
  );

  xfer_loop_dp #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .STALL_W(STALL_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr),
    .cfgSrcOff(cfgSrcOff), .cfgDstOff(cfgDstOff),
    .cfgSrcSize(cfgSrcSize), .cfgDstSize(cfgDstSize),
    .cfgByteWord(cfgByteWord), .cfgMapEn(cfgMapEn),
    .cfgSrcLast(cfgSrcLast), .cfgDstLast(cfgDstLast),
    .cfgIter(cfgIter), .cfgStall(cfgStall), .cfgIntEn(cfgIntEn),
    .strb(strb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .rdSize(rdSize), .wrSize(wrSize),
    .unitsTotal(unitsTotal), .rdPerUnit(rdPerUnit), .wrPerUnit(wrPerUnit),
    .stallCyc(stallCyc), .cfgErr(cfgErr),
    .minorDone(minorDone), .majorDone(majorDone), .doneFlag(doneFlag),
    .irq(irq), .curIter(curIter)
  );

endmodule

// File: rtl/xfer_loop_chk.sv
module xfer_loop_chk #(
  parameter int ITER_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgLoad,
  input logic              svcReq,
  input logic              rdEn,
  input logic              wrEn,
  input logic              active,
  input logic              minorDone,
  input logic              majorDone,
  input logic              doneFlag,
  input logic              irq,
  input logic              cfgErr,
  input logic [ITER_W-1:0] curIter
);

  // R11
  no_rdwr_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));

  // R8
  idle_no_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (!rdEn && !wrEn));

  // R10
  err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !active && svcReq) |=> !active);

  // R5
  iter_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minorDone && !majorDone && !$past(cfgLoad)) |-> (curIter == $past(curIter) - ITER_W'(1)));

  // R6
  major_sets_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    majorDone |-> (doneFlag && minorDone));

  // R7
  irq_needs_major_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> majorDone);

endmodule

bind xfer_loop_seq xfer_loop_chk #(.ITER_W(ITER_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .svcReq(svcReq),
  .rdEn(rdEn), .wrEn(wrEn), .active(active),
  .minorDone(minorDone), .majorDone(majorDone), .doneFlag(doneFlag),
  .irq(irq), .cfgErr(cfgErr), .curIter(curIter)
);

// File: tb/xfer_loop_seq_bench.sv
`timescale 1ns/1ps
module xfer_loop_seq_bench;

  localparam int ADDR_W = 32, ITER_W = 15, STALL_W = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgLoad = 1'b0, cfgMapEn = 1'b0, cfgIntEn = 1'b0, svcReq = 1'b0;
  logic [ADDR_W-1:0] cfgSrcAddr = '0, cfgDstAddr = '0, cfgSrcLast = '0, cfgDstLast = '0;
  logic [15:0] cfgSrcOff = '0, cfgDstOff = '0;
  logic [2:0] cfgSrcSize = '0, cfgDstSize = '0;
  logic [31:0] cfgByteWord = '0;
  logic [ITER_W-1:0] cfgIter = '0;
  logic [STALL_W-1:0] cfgStall = '0;
  logic rdEn, wrEn, active, minorDone, majorDone, doneFlag, irq, cfgErr;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [2:0] rdSize, wrSize;
  logic [ITER_W-1:0] curIter;

  always #2.5 clk = ~clk;

  xfer_loop_seq #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .STALL_W(STALL_W)) u_xfer_loop_seq (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr),
    .cfgSrcOff(cfgSrcOff), .cfgDstOff(cfgDstOff),
    .cfgSrcSize(cfgSrcSize), .cfgDstSize(cfgDstSize),
    .cfgByteWord(cfgByteWord), .cfgMapEn(cfgMapEn),
    .cfgSrcLast(cfgSrcLast), .cfgDstLast(cfgDstLast),
    .cfgIter(cfgIter), .cfgStall(cfgStall), .cfgIntEn(cfgIntEn), .svcReq(svcReq),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdSize(rdSize),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .active(active), .minorDone(minorDone), .majorDone(majorDone),
    .doneFlag(doneFlag), .irq(irq), .cfgErr(cfgErr), .curIter(curIter)
  );

  int nChecks = 0, nFails = 0, cycles = 0;

  // bench model of the descriptor
  logic [31:0] mSrc, mDst, mSlast, mDlast, mWord;
  logic [15:0] mSoff, mDoff;
  logic [2:0]  mSc, mDc;
  logic        mMap, mIntEn;
  logic [ITER_W-1:0] mBegin, mIter;
  logic [STALL_W-1:0] mStall;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFails++;
      $display("FAIL watchdog: run did not end, act=%0d exp<=%0d", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic setModel(input logic [31:0] s, d, input logic [15:0] so, dof,
                          input logic [2:0] sc, dc, input logic [31:0] w, input logic map,
                          input logic [31:0] sl, dl, input logic [ITER_W-1:0] it,
                          input logic [STALL_W-1:0] st, input logic ie);
    mSrc = s; mDst = d; mSoff = so; mDoff = dof; mSc = sc; mDc = dc; mWord = w;
    mMap = map; mSlast = sl; mDlast = dl; mBegin = it; mIter = it; mStall = st; mIntEn = ie;
  endtask

  task automatic applyDesc();
    @(negedge clk);
    cfgSrcAddr = mSrc; cfgDstAddr = mDst; cfgSrcOff = mSoff; cfgDstOff = mDoff;
    cfgSrcSize = mSc; cfgDstSize = mDc; cfgByteWord = mWord; cfgMapEn = mMap;
    cfgSrcLast = mSlast; cfgDstLast = mDlast; cfgIter = mBegin; cfgStall = mStall;
    cfgIntEn = mIntEn; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  // one service request; checks every access and the end-of-loop state
  task automatic runMinor(input string tag, input bit poke);
    logic [31:0] nb, ml;
    bit sml, dml, expMajor, minorSeen, majorSeen, irqSeen, doneAtStart, wantRead;
    int rdCnt, wrCnt, actCyc, seqErr, rpu, wpu, mc;
    rdCnt = 0; wrCnt = 0; actCyc = 0; seqErr = 0;
    minorSeen = 0; majorSeen = 0; irqSeen = 0; doneAtStart = 1;
    sml = mMap && mWord[31];
    dml = mMap && mWord[30];
    if (!mMap) nb = mWord;
    else if (mWord[31] || mWord[30]) nb = {22'd0, mWord[9:0]};
    else nb = {2'd0, mWord[29:0]};
    ml = {{12{mWord[29]}}, mWord[29:10]};
    mc = (mSc > mDc) ? int'(mSc) : int'(mDc);
    rpu = 1 << (mc - int'(mSc));
    wpu = 1 << (mc - int'(mDc));
    expMajor = (mIter == ITER_W'(1));
    @(negedge clk); svcReq = 1'b1;
    @(negedge clk); svcReq = 1'b0;
    for (int cyc = 0; cyc < 40000; cyc++) begin
      if (cyc == 0) doneAtStart = doneFlag;
      if (minorDone) minorSeen = 1;
      if (majorDone) majorSeen = 1;
      if (irq) irqSeen = 1;
      if (!active) break;
      actCyc++;
      wantRead = (rdCnt < (wrCnt / wpu + 1) * rpu);
      if (rdEn) begin
        if (!wantRead) seqErr++;
        check(rdAddr == mSrc && rdSize == mSc, "R1", {tag, " read address/size"}, rdAddr, mSrc);
        mSrc = mSrc + {{16{mSoff[15]}}, mSoff};
        rdCnt++;
      end
      if (wrEn) begin
        if (wantRead) seqErr++;
        check(wrAddr == mDst && wrSize == mDc, "R1", {tag, " write address/size"}, wrAddr, mDst);
        mDst = mDst + {{16{mDoff[15]}}, mDoff};
        wrCnt++;
      end
      if (poke && cyc == 2) svcReq = 1'b1;
      if (poke && cyc == 3) svcReq = 1'b0;
      @(negedge clk);
    end
    svcReq = 1'b0;
    if (sml) mSrc = mSrc + ml;
    if (dml) mDst = mDst + ml;
    if (expMajor) begin
      mSrc = mSrc + mSlast; mDst = mDst + mDlast; mIter = mBegin;
    end else mIter = mIter - ITER_W'(1);
    check(rdCnt == int'(nb >> mSc), "R2", {tag, " read count"}, rdCnt, nb >> mSc);
    check(wrCnt == int'(nb >> mDc), "R2", {tag, " write count"}, wrCnt, nb >> mDc);
    check(seqErr == 0, "R2", {tag, " unit read/write order"}, seqErr, 0);
    check(actCyc == (rdCnt + wrCnt) * (1 + int'(mStall)), "R9", {tag, " active cycles"},
          actCyc, (rdCnt + wrCnt) * (1 + int'(mStall)));
    check(doneAtStart == 0, "R6", {tag, " done cleared at start"}, doneAtStart, 0);
    check(minorSeen, "R5", {tag, " minor pulse"}, minorSeen, 1);
    check(curIter == mIter, "R5", {tag, " iteration count"}, curIter, mIter);
    check(majorSeen == expMajor, "R6", {tag, " major pulse"}, majorSeen, expMajor);
    check(doneFlag == expMajor, "R6", {tag, " done flag"}, doneFlag, expMajor);
    check(irqSeen == (expMajor && mIntEn), "R7", {tag, " interrupt"}, irqSeen, expMajor && mIntEn);
    check(rdAddr == mSrc, "R4", {tag, " source after loop"}, rdAddr, mSrc);
    check(wrAddr == mDst, "R4", {tag, " destination after loop"}, wrAddr, mDst);
    if (poke) begin
      int late = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (active || rdEn || wrEn) late++;
      end
      check(late == 0, "R8", {tag, " request while busy ignored"}, late, 0);
    end
  endtask

  task automatic t_reset();
    check(!active && !rdEn && !wrEn, "R8", "reset idle", {active, rdEn, wrEn}, 0);
    check(cfgErr == 1'b1, "R10", "reset descriptor invalid", cfgErr, 1);
    check(curIter == '0 && !doneFlag, "R6", "reset counters", curIter, 0);
  endtask

  task automatic t_mem2mem();
    setModel(32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 32'd8, 1'b0,
             -32'sd16, -32'sd16, 15'd2, 2'd0, 1'b1);
    applyDesc();
    check(cfgErr == 1'b0, "R10", "valid descriptor accepted", cfgErr, 0);
    runMinor("mem2mem first", 1'b0);
    runMinor("mem2mem last busy", 1'b1);
    check(rdAddr == 32'h1000 && wrAddr == 32'h2000, "R6", "rewound by end adjustment", rdAddr, 32'h1000);
  endtask

  task automatic t_mixedWidth();
    // 1-byte reads into 4-byte writes, negative destination step, no interrupt
    setModel(32'h3000, 32'h4100, 16'd1, -16'sd4, 3'd0, 3'd2, 32'd8, 1'b0,
             32'd0, 32'd0, 15'd1, 2'd0, 1'b0);
    applyDesc();
    runMinor("narrow to wide", 1'b0);
    // 32-byte reads into 16-byte writes
    setModel(32'h8000, 32'h9000, 16'd32, 16'd16, 3'd5, 3'd4, 32'd64, 1'b0,
             32'd0, 32'd0, 15'd1, 2'd0, 1'b1);
    applyDesc();
    runMinor("wide to narrow", 1'b0);
  endtask

  task automatic t_wholeWord();
    // R3: map off, bits above 9 are part of the byte count (0x410 = 1040 bytes)
    setModel(32'h10000, 32'h20000, 16'd16, 16'd4, 3'd4, 3'd2, 32'h0000_0410, 1'b0,
             32'd0, 32'd0, 15'd2, 2'd0, 1'b0);
    applyDesc();
    runMinor("R3 full word count", 1'b0);
  endtask

  task automatic t_minorOffset();
    // R4: both offset enables, offset -8, count 4
    setModel(32'h5000, 32'h6000, 16'd1, 16'd1, 3'd0, 3'd0,
             {1'b1, 1'b1, 20'hFFFF8, 10'd4}, 1'b1, 32'd100, 32'd200, 15'd3, 2'd0, 1'b1);
    applyDesc();
    runMinor("R4 offset loop1", 1'b0);
    runMinor("R4 offset loop2", 1'b0);
    runMinor("R4 offset loop3", 1'b0);
    // R4: map on, only source enable
    setModel(32'h5000, 32'h6000, 16'd2, 16'd2, 3'd1, 3'd1,
             {1'b1, 1'b0, 20'h00010, 10'd6}, 1'b1, 32'd0, 32'd0, 15'd2, 2'd0, 1'b0);
    applyDesc();
    runMinor("R4 source-only offset", 1'b0);
    // R4: map on, no enables, bits 29:0 are the count (0x402 = 1026 bytes)
    setModel(32'h7000, 32'h7800, 16'd2, 16'd2, 3'd1, 3'd1, 32'h0000_0402, 1'b1,
             32'd0, 32'd0, 15'd1, 2'd0, 1'b0);
    applyDesc();
    runMinor("R4 no-offset layout", 1'b0);
  endtask

  task automatic t_stall();
    setModel(32'hA000, 32'hB000, 16'd2, 16'd2, 3'd1, 3'd1, 32'd4, 1'b0,
             32'd0, 32'd0, 15'd1, 2'd2, 1'b1);
    applyDesc();
    runMinor("R9 stall two", 1'b0);
    setModel(32'hA000, 32'hB000, 16'd4, 16'd0, 3'd2, 3'd2, 32'd8, 1'b0,
             32'd0, 32'd0, 15'd1, 2'd3, 1'b0);
    applyDesc();
    runMinor("R9 stall three", 1'b0);
  endtask

  task automatic errCase(input string tag);
    int seen = 0;
    applyDesc();
    check(cfgErr == 1'b1, "R10", {tag, " flagged"}, cfgErr, 1);
    @(negedge clk); svcReq = 1'b1;
    @(negedge clk); svcReq = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (active || rdEn || wrEn) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10", {tag, " request ignored"}, seen, 0);
  endtask

  task automatic t_errors();
    setModel(32'h0, 32'h0, 16'd1, 16'd1, 3'd3, 3'd0, 32'd8, 1'b0, 32'd0, 32'd0, 15'd1, 2'd0, 1'b0);
    errCase("size code 3");
    setModel(32'h0, 32'h0, 16'd4, 16'd4, 3'd2, 3'd0, 32'd6, 1'b0, 32'd0, 32'd0, 15'd1, 2'd0, 1'b0);
    errCase("count not multiple");
    setModel(32'h0, 32'h0, 16'd4, 16'd4, 3'd2, 3'd2, 32'd8, 1'b0, 32'd0, 32'd0, 15'd0, 2'd0, 1'b0);
    errCase("zero iterations");
    setModel(32'h0, 32'h0, 16'd4, 16'd4, 3'd2, 3'd2, {1'b1, 1'b0, 20'd5, 10'd0}, 1'b1,
             32'd0, 32'd0, 15'd1, 2'd0, 1'b0);
    errCase("zero byte count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem2mem();
    t_mixedWidth();
    t_wholeWord();
    t_minorOffset();
    t_stall();
    t_errors();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule